// File: doc/BRIEF.md
# Packet Register Stage with Trailing Parity Check

This block is the byte datapath stage that sits between the input port of a small packet router and its destination queues. A separate sequencer, outside this block, walks each packet through its phases and drives one-hot phase strobes. Under those strobes this stage latches the address byte and replays it one cycle later. It passes payload bytes straight through to the queue write bus. When the destination queue is full, it parks the byte that arrived and replays it once space is free again.

While the packet streams in, the stage folds the address byte and every payload byte into a running XOR. The source marks the last byte, the trailing check byte, by dropping its valid line. The stage captures that byte, raises a done flag, and one cycle later raises an error flag if the check byte and the running XOR differ. Each new address byte restarts the XOR, the done flag and the error flag, so packets are checked one after another with no software action in between.

Top module: `pkt_parity_reg`

## Requirements
- R1: While rstN is low, at each clock edge dout, err, parityDone and lowPktValid go to 0, whatever the other inputs are.
- R2: An edge with detectAdd and pktValid both high stores dataIn as the address byte. At the next edge with lfdState high, dout takes that stored byte.
- R3: An edge with ldState high, fifoFull low and lfdState low loads dout with the dataIn of that cycle.
- R4: An edge with ldState and fifoFull both high leaves dout unchanged and parks dataIn. A later edge with lafState high (and lfdState and ldState low) loads dout with the parked byte. An edge with none of lfdState, ldState or lafState high leaves dout unchanged.
- R5: lowPktValid is set by an edge with ldState high and pktValid low, and cleared by an edge with rstIntReg high. rstIntReg wins when both apply.
- R6: parityDone is set by an edge with ldState high and both fifoFull and pktValid low. It is cleared by an edge with detectAdd high and otherwise stays set.
- R7: The running parity is the XOR of the address byte (folded at the lfdState edge) and of every byte presented with ldState and pktValid high and fullState low, including bytes parked because fifoFull was high.
- R8: err changes only on the edge after a cycle in which parityDone is high, when it takes the value (check byte != running parity), or on an edge with detectAdd high, which clears it.
- R9: An edge with lafState high, lowPktValid high and parityDone low sets parityDone and takes the parked byte as the check byte, so a check byte that arrives while the queue is full is still checked.
- R10: The check byte (the one presented with pktValid low) is not folded into the running parity. A packet whose check byte equals the XOR of its address and payload bytes ends with err low.
- R11: The running parity clears on detectAdd, so a packet that follows a corrupted one is checked on its own bytes alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| pktValid | input | 1 | Source byte valid; low marks the check byte |
| dataIn | input | 8 | Byte from the source |
| fifoFull | input | 1 | Full flag of the selected destination queue |
| detectAdd | input | 1 | Sequencer strobe: address byte present |
| ldState | input | 1 | Sequencer strobe: payload load phase |
| lafState | input | 1 | Sequencer strobe: replay of the parked byte |
| fullState | input | 1 | Sequencer strobe: stalled on a full queue |
| lfdState | input | 1 | Sequencer strobe: address byte written to queue |
| rstIntReg | input | 1 | Sequencer strobe: clear the low-valid flag |
| dout | output | 8 | Byte driven to the queue write bus |
| parityDone | output | 1 | Check byte has been captured |
| lowPktValid | output | 1 | Source dropped valid during the load phase |
| err | output | 1 | Check byte and running parity differ |

## Verification
On every cycle, the assertions check how dout follows the address, payload and parked-byte paths. They also check the set and clear rules of lowPktValid and parityDone, including the replay path that sets parityDone, and that err moves only after parityDone or on a new address. Whether the running parity really covers the right bytes can only be seen through the bench's packets. Those include clean and corrupted packets, a stall in the middle of the payload, a check byte parked behind a full queue, a clean packet right after a corrupted one, and a reset in the middle of a packet.

// File: rtl/pkt_parity_pkg.sv
package pkt_parity_pkg;

  // Source of the next value of the byte bus.
  typedef enum logic [1:0] {
    DOUT_KEEP   = 2'd0,
    DOUT_HEADER = 2'd1,
    DOUT_DATA   = 2'd2,
    DOUT_HOLD   = 2'd3
  } doutSel_e;

  // Source of the captured check byte.
  typedef enum logic [1:0] {
    CHK_KEEP      = 2'd0,
    CHK_FROM_IN   = 2'd1,
    CHK_FROM_HOLD = 2'd2
  } chkSrc_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic     loadHeader;
    logic     loadHold;
    doutSel_e doutSel;
    logic     clearParity;
    logic     foldHeader;
    logic     foldData;
    chkSrc_e  chkSrc;
    logic     clearErr;
    logic     evalErr;
  } dpStrobe_t;

endpackage

// File: rtl/pkt_parity_ctrl.sv
module pkt_parity_ctrl
  import pkt_parity_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pktValid,
  input  logic      fifoFull,
  input  logic      detectAdd,
  input  logic      ldState,
  input  logic      lafState,
  input  logic      fullState,
  input  logic      lfdState,
  input  logic      rstIntReg,
  output dpStrobe_t strobe,
  output logic      parityDone,
  output logic      lowPktValid
);

  logic ldDoneHit;
  logic lafDoneHit;

  // The check byte goes straight through, or comes back from the park register.
  assign ldDoneHit  = ldState && !fifoFull && !pktValid;
  assign lafDoneHit = lafState && lowPktValid && !parityDone;

  always_comb begin
    strobe             = '0;
    strobe.loadHeader  = detectAdd && pktValid;
    strobe.loadHold    = ldState && fifoFull;
    strobe.clearParity = detectAdd;
    strobe.foldHeader  = lfdState;
    strobe.foldData    = ldState && pktValid && !fullState;
    strobe.clearErr    = detectAdd;
    strobe.evalErr     = parityDone;

    if (lfdState)                  strobe.doutSel = DOUT_HEADER;
    else if (ldState && !fifoFull) strobe.doutSel = DOUT_DATA;
    else if (lafState)             strobe.doutSel = DOUT_HOLD;
    else                           strobe.doutSel = DOUT_KEEP;

    if (ldDoneHit)       strobe.chkSrc = CHK_FROM_IN;
    else if (lafDoneHit) strobe.chkSrc = CHK_FROM_HOLD;
    else                 strobe.chkSrc = CHK_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      lowPktValid <= 1'b0;
    else if (rstIntReg)             lowPktValid <= 1'b0;
    else if (ldState && !pktValid)  lowPktValid <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                        parityDone <= 1'b0;
    else if (detectAdd)               parityDone <= 1'b0;
    else if (ldDoneHit || lafDoneHit) parityDone <= 1'b1;
  end

  assert_low_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ldState && !pktValid && !rstIntReg) |=> lowPktValid);

  assert_low_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    rstIntReg |=> !lowPktValid);

  assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    detectAdd |=> !parityDone);

  assert_done_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ldState && !fifoFull && !pktValid && !detectAdd) |=> parityDone);

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (parityDone && !detectAdd) |=> parityDone);

  assert_replay_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lafState && lowPktValid && !parityDone && !detectAdd) |=> parityDone);

endmodule

// File: rtl/pkt_parity_dp.sv
module pkt_parity_dp
  import pkt_parity_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] dout,
  output logic              err
);

  logic [DATA_W-1:0] headerReg;
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] runParity;
  logic [DATA_W-1:0] runParityNext;
  logic [DATA_W-1:0] chkByte;

  always_comb begin
    runParityNext = runParity;
    if (strobe.foldHeader) runParityNext = runParityNext ^ headerReg;
    if (strobe.foldData)   runParityNext = runParityNext ^ dataIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headerReg <= '0;
      holdReg   <= '0;
    end else begin
      if (strobe.loadHeader) headerReg <= dataIn;
      if (strobe.loadHold)   holdReg   <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dout <= '0;
    else begin
      case (strobe.doutSel)
        DOUT_HEADER: dout <= headerReg;
        DOUT_DATA:   dout <= dataIn;
        DOUT_HOLD:   dout <= holdReg;
        default:     dout <= dout;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   runParity <= '0;
    else if (strobe.clearParity) runParity <= '0;
    else                         runParity <= runParityNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) chkByte <= '0;
    else begin
      case (strobe.chkSrc)
        CHK_FROM_IN:   chkByte <= dataIn;
        CHK_FROM_HOLD: chkByte <= holdReg;
        default:       chkByte <= chkByte;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                err <= 1'b0;
    else if (strobe.clearErr) err <= 1'b0;
    else if (strobe.evalErr)  err <= (chkByte != runParity);
  end

  assert_parity_restart_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearParity |=> (runParity == '0));

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearErr |=> !err);

endmodule

// File: rtl/pkt_parity_reg.sv
module pkt_parity_reg
  import pkt_parity_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktValid,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              fifoFull,
  input  logic              detectAdd,
  input  logic              ldState,
  input  logic              lafState,
  input  logic              fullState,
  input  logic              lfdState,
  input  logic              rstIntReg,
  output logic [DATA_W-1:0] dout,
  output logic              parityDone,
  output logic              lowPktValid,
  output logic              err
);

  dpStrobe_t strobe;

  pkt_parity_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pktValid    (pktValid),
    .fifoFull    (fifoFull),
    .detectAdd   (detectAdd),
    .ldState     (ldState),
    .lafState    (lafState),
    .fullState   (fullState),
    .lfdState    (lfdState),
    .rstIntReg   (rstIntReg),
    .strobe      (strobe),
    .parityDone  (parityDone),
    .lowPktValid (lowPktValid)
  );

  pkt_parity_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .dataIn (dataIn),
    .strobe (strobe),
    .dout   (dout),
    .err    (err)
  );

  assert_header_replay_R2: assert property (@(posedge clk) disable iff (!rstN)
    (detectAdd && pktValid) ##1 (lfdState && !(detectAdd && pktValid))
      |=> (dout == $past(dataIn, 2)));

  assert_payload_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ldState && !fifoFull && !lfdState) |=> (dout == $past(dataIn)));

  assert_park_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ldState && fifoFull && !lfdState) |=> $stable(dout));

  assert_park_replay_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ldState && fifoFull && !lfdState) ##1 (lafState && !lfdState && !ldState)
      |=> (dout == $past(dataIn, 2)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!lfdState && !ldState && !lafState) |=> $stable(dout));

  assert_err_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> $past(parityDone));

  assert_err_still_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!parityDone && !detectAdd) |=> $stable(err));

endmodule

// File: tb/pkt_parity_reg_bench.sv
module pkt_parity_reg_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       pktValid, fifoFull, detectAdd, ldState, lafState;
  logic       fullState, lfdState, rstIntReg;
  logic [7:0] dataIn;
  logic [7:0] dout;
  logic       parityDone, lowPktValid, err;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;
  logic [7:0] expDout;
  logic [7:0] expPar;

  always #4 clk = ~clk;

  pkt_parity_reg #(.DATA_W(8)) u_pkt_parity_reg (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .dataIn(dataIn),
    .fifoFull(fifoFull), .detectAdd(detectAdd), .ldState(ldState),
    .lafState(lafState), .fullState(fullState), .lfdState(lfdState),
    .rstIntReg(rstIntReg), .dout(dout), .parityDone(parityDone),
    .lowPktValid(lowPktValid), .err(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    pktValid = 0; fifoFull = 0; detectAdd = 0; ldState = 0; lafState = 0;
    fullState = 0; lfdState = 0; rstIntReg = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic doHeader(input logic [7:0] hdr);
    idle(); detectAdd = 1; pktValid = 1; dataIn = hdr;
    step();
    check("R6 done cleared by address", parityDone, 0);
    check("R8 err cleared by address", err, 0);
    idle(); lfdState = 1; pktValid = 1; dataIn = ~hdr;
    step();
    expDout = hdr;
    check("R2 address replay", dout, hdr);
    expPar = hdr;
  endtask

  task automatic ldByte(input logic [7:0] b, input bit last);
    idle(); ldState = 1; pktValid = !last; dataIn = b;
    step();
    expDout = b;
    check("R3 payload pass", dout, b);
    if (!last) expPar = expPar ^ b;
    else begin
      check("R6 done on check byte", parityDone, 1);
      check("R5 low valid set", lowPktValid, 1);
    end
  endtask

  task automatic stalledByte(input logic [7:0] b, input bit last);
    idle(); ldState = 1; fifoFull = 1; pktValid = !last; dataIn = b;
    step();
    check("R4 dout held while full", dout, expDout);
    if (last) begin
      check("R5 low valid set while full", lowPktValid, 1);
      check("R6 done not set while full", parityDone, 0);
    end else expPar = expPar ^ b;
    idle(); fullState = 1; fifoFull = 1; pktValid = 1; dataIn = ~b;
    step();
    check("R4 dout held in stall", dout, expDout);
    idle(); lafState = 1; pktValid = !last; dataIn = 8'h00;
    step();
    expDout = b;
    check("R4 parked byte replay", dout, b);
    if (last) check("R9 done via replay", parityDone, 1);
  endtask

  task automatic finishPkt(input bit expErr);
    idle(); dataIn = 8'hA5;
    step();
    check("R8 err after check byte", err, expErr);
    check("R4 dout idle hold", dout, expDout);
    idle(); rstIntReg = 1;
    step();
    check("R5 low valid cleared", lowPktValid, 0);
    check("R6 done stays set", parityDone, 1);
    check("R8 err stable", err, expErr);
    idle();
  endtask

  task automatic tReset();
    rstN = 0; pktValid = 1; detectAdd = 1; ldState = 1; lafState = 1;
    lfdState = 1; fifoFull = 0; fullState = 0; rstIntReg = 0; dataIn = 8'hFF;
    step(); step();
    check("R1 reset dout", dout, 0);
    check("R1 reset err", err, 0);
    check("R1 reset parityDone", parityDone, 0);
    check("R1 reset lowPktValid", lowPktValid, 0);
    idle(); rstN = 1;
    step();
    expDout = 0;
  endtask

  task automatic tGoodPacket();
    doHeader(8'h3C);
    ldByte(8'h11, 0); ldByte(8'h82, 0); ldByte(8'h5F, 0); ldByte(8'hE0, 0);
    ldByte(expPar, 1);   // R10 matching check byte
    finishPkt(0);
  endtask

  task automatic tBadThenGood();
    doHeader(8'h9A);
    ldByte(8'h01, 0); ldByte(8'h77, 0);
    ldByte(expPar ^ 8'h10, 1);
    finishPkt(1);
    // R11: fresh packet after a corrupted one
    doHeader(8'h44);
    ldByte(8'hC3, 0); ldByte(8'h2B, 0); ldByte(8'h90, 0);
    ldByte(expPar, 1);
    finishPkt(0);
  endtask

  task automatic tStallPayload();
    doHeader(8'h5A);
    ldByte(8'h21, 0);
    stalledByte(8'hB7, 0);   // R7 parked payload byte still folded
    ldByte(8'h6E, 0);
    ldByte(expPar, 1);
    finishPkt(0);
  endtask

  task automatic tStallCheckByte(input bit corrupt);
    doHeader(8'hD1);
    ldByte(8'h0F, 0); ldByte(8'hF0, 0); ldByte(8'h33, 0);
    stalledByte(corrupt ? (expPar ^ 8'h01) : expPar, 1);
    finishPkt(corrupt);
  endtask

  task automatic tResetMidPacket();
    doHeader(8'h12);
    ldByte(8'h34, 0);
    ldByte(8'h00, 1);
    idle(); step();
    check("R8 err on wrong check byte", err, 1);
    rstN = 0;
    step();
    check("R1 mid reset dout", dout, 0);
    check("R1 mid reset err", err, 0);
    check("R1 mid reset parityDone", parityDone, 0);
    check("R1 mid reset lowPktValid", lowPktValid, 0);
    rstN = 1;
    step();
    expDout = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle(); rstN = 0; dataIn = 0;
    #1;
    tReset();
    tGoodPacket();
    tBadThenGood();
    tStallPayload();
    tStallCheckByte(0);
    tStallCheckByte(1);
    tResetMidPacket();
    tGoodPacket();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule